// File: doc/BRIEF.md
# Two-Wire Block-Transfer Configuration Slave

This block is a serial slave on a two-wire bus (clock line and open-drain data line) that keeps the configuration register image of a clock controller. It responds to one bus address for writes and another for reads. Neither direction uses a register pointer: every transfer begins at register 0 and walks upward one byte at a time.

A write carries two leading bytes that the slave accepts and throws away, a command code and a byte count. All later bytes land in registers 0, 1, 2 and so on. A read first returns the value of the length register and then streams registers from 0 upward. The stream stops at a register index that software sets through that same length register, so the master does not decide the read length. The whole register image is brought out in parallel to the surrounding chip logic. The data line is driven only low, through an enable. Both bus lines are brought into the system clock domain by two-flop synchronisers before any edge or bus condition is decoded.

Top module: `cfgs_slave`

## Requirements
- R1: The slave acknowledges the address byte 8'hD2 (write) and 8'hD3 (read). It acknowledges no other address, and the bytes of a transfer with another address are neither acknowledged nor stored.
- R2: In a write, the first and second bytes after the address are discarded. The k-th later byte (k from 0) is stored in register k.
- R3: Every byte of a write to 8'hD2 is acknowledged, including bytes past the last register (index NREG-1 = 20). Those bytes change no register.
- R4: Register 7 is read-only and always reads 8'hCB with default parameters (vendor code 3'b110 in bits 7:5, revision 5'h0B in bits 4:0). Writes to it have no effect.
- R5: Register 8 (read length) resets to 8'h08. A write of 8'h00 to it is ignored and any other value is stored, so it is never zero.
- R6: A read sends register 8's value first. It then sends registers 0 up to and including register min(reg8, 20). After that byte the slave leaves the data line released for the rest of the transfer, so extra bytes read as 8'hFF.
- R7: A not-acknowledge from the master after any read byte makes the slave release the data line and go idle, so any further bytes read as 8'hFF.
- R8: A STOP returns the slave to idle with the data line released. A repeated START at any point abandons the current transfer and starts address matching again.
- R9: The slave changes its data-line drive only while the synchronised clock line is low. START and STOP are recognised from data-line edges while the clock line is high.
- R10: After reset, registers 0-6 and 9-20 read 8'h00, register 8 reads 8'h08, register 7 reads its fixed code, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| cfg_regs | output | NREG*8 | Register image; register k occupies bits 8k+7:8k |

## Verification
The assertions assume a well-behaved master: the data line moves only while the clock line is low, except to form START or STOP, and each clock-line level lasts several system clocks, so the synchroniser delay never reorders the two lines. They also assume the master never attempts START or STOP while the slave is pulling the data line low. The bench master holds each bus phase for four or eight system clocks, drives new data in the middle of the low phase, and issues a repeated START only after an acknowledge cycle has completed. This keeps all stimulus within those assumptions.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for START
    S_ADDR,   // shifting in the address byte
    S_ACK,    // slave pulling data low for one acknowledge bit
    S_WBYTE,  // shifting in a write byte
    S_RBYTE,  // shifting out a read byte
    S_RACK,   // sampling the master's acknowledge
    S_RNEXT,  // acknowledged, next byte loads on clock fall
    S_DONE    // detached until START or STOP
  } link_st_t;

  // A write to register idx with data d takes effect only when this is true.
  function automatic logic wr_allowed(input int unsigned idx, input logic [7:0] d,
                                      input int unsigned nreg);
    return (idx < nreg) && (idx != 7) && !((idx == 8) && (d == 8'h00));
  endfunction

  // Highest register index sent by a read for a given length value.
  function automatic int unsigned last_rd_reg(input logic [7:0] len, input int unsigned nreg);
    return (32'(len) > nreg - 1) ? nreg - 1 : 32'(len);
  endfunction

endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;

  // Idle bus is high, so the chains reset high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_m[1];
      sda_q <= sda_m[1];
    end
  end

  assign scl_s    = scl_m[1];
  assign sda_s    = sda_m[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile #(
  parameter int          NREG   = 21,
  parameter logic [2:0]  VENDOR = 3'b110,
  parameter logic [4:0]  REV    = 5'h0B,
  localparam int         IW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        len_reg,
  output logic [NREG*8-1:0] regs_flat
);
  import cfgs_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 7) begin : g_id
      assign regs_flat[g*8 +: 8] = {VENDOR, REV};
    end else begin : g_rw
      localparam logic [7:0] RSTV = (g == 8) ? 8'h08 : 8'h00;
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RSTV;
        else if (wr_req && wr_idx == IW'(g) && wr_allowed(g, wr_data, NREG)) r <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = r;
    end
  end

  assign len_reg = regs_flat[8*8 +: 8];
  assign rd_data = regs_flat[{rd_idx, 3'b000} +: 8];

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    len_reg != 8'h00);  // R5
  AST_ZERO_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_idx == IW'(8) && wr_data == 8'h00) |=> $stable(len_reg));  // R5

endmodule

// File: rtl/cfgs_link.sv
module cfgs_link #(
  parameter int         NREG    = 21,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3,
  localparam int        IW      = $clog2(NREG),
  localparam int        PW      = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    len_reg,
  output logic          sda_oe,
  output logic          wr_req,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] rd_idx
);
  import cfgs_pkg::*;

  link_st_t      st;
  logic          is_rd;
  logic [3:0]    bitc;
  logic [7:0]    sh;
  logic [7:0]    wcnt;      // bytes received after the address, saturating
  logic [PW-1:0] pos;       // 0 = length byte, k = register k-1
  logic [PW-1:0] last_pos;
  logic          byte_in_done;
  logic          wr_hit;

  assign last_pos     = PW'(last_rd_reg(len_reg, NREG) + 1);
  assign rd_idx       = (pos == '0) ? '0 : IW'(pos - 1'b1);
  assign byte_in_done = scl_fall && (bitc == 4'd8);
  assign wr_hit       = (wcnt >= 8'd2) && ((32'(wcnt) - 2) < NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_rd   <= 1'b0;
      bitc    <= '0;
      sh      <= '0;
      wcnt    <= '0;
      pos     <= '0;
      sda_oe  <= 1'b0;
      wr_req  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_ev) begin
        st     <= S_ADDR;
        bitc   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE, S_DONE: ;
          S_ADDR: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (byte_in_done) begin
              if (sh == WR_ADDR || sh == RD_ADDR) begin
                is_rd  <= (sh == RD_ADDR);
                st     <= S_ACK;
                sda_oe <= 1'b1;
                wcnt   <= '0;
                pos    <= '0;
              end else begin
                st <= S_DONE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitc <= '0;
              if (is_rd) begin
                sh     <= len_reg;
                sda_oe <= ~len_reg[7];
                st     <= S_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WBYTE;
              end
            end
          end
          S_WBYTE: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (byte_in_done) begin
              st      <= S_ACK;
              sda_oe  <= 1'b1;
              wr_req  <= wr_hit;
              wr_idx  <= IW'(wcnt - 8'd2);
              wr_data <= sh;
              if (wcnt != 8'hFF) wcnt <= wcnt + 8'd1;
            end
          end
          S_RBYTE: begin
            if (scl_fall) begin
              if (bitc == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                bitc   <= bitc + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s)                st <= S_IDLE;
              else if (pos == last_pos) st <= S_DONE;
              else begin
                pos <= pos + 1'b1;
                st  <= S_RNEXT;
              end
            end
          end
          S_RNEXT: begin
            if (scl_fall) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              bitc   <= '0;
              st     <= S_RBYTE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == S_IDLE && !sda_oe));  // R8
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_ADDR && bitc == 4'd0));  // R8
  AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));  // R9
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (32'(wr_idx) < NREG));  // R3
  AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl_rise && sda_s && !start_ev && !stop_ev) |=> (!sda_oe && st == S_IDLE));  // R7

endmodule

// File: rtl/cfgs_slave.sv
module cfgs_slave #(
  parameter int         NREG    = 21,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3,
  parameter logic [2:0] VENDOR  = 3'b110,
  parameter logic [4:0] REV     = 5'h0B,
  localparam int        IW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_regs
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          wr_req;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data, len_reg;

  cfgs_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  cfgs_link #(.NREG(NREG), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .len_reg(len_reg), .sda_oe(sda_oe),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx)
  );

  cfgs_regfile #(.NREG(NREG), .VENDOR(VENDOR), .REV(REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .len_reg(len_reg), .regs_flat(cfg_regs)
  );

endmodule

// File: tb/tb_cfgs_slave.sv
module tb_cfgs_slave;
  localparam int         NR    = 21;
  localparam logic [7:0] ID_V  = 8'hCB;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, bus;
  logic [NR*8-1:0] cfg;
  assign bus = sda_m & ~sda_oe;

  cfgs_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus),
                  .sda_oe(sda_oe), .cfg_regs(cfg));

  always #2 clk = ~clk;

  int   mdl[NR];
  int   vec = 0, bad = 0;
  logic cmp_en = 1'b0, fin = 1'b0;
  logic [7:0] wbuf[32];

  function automatic logic [NR*8-1:0] model_image();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = 8'(mdl[i]);
    return v;
  endfunction

  // Reference store rule, restated from R2-R5.
  task automatic model_store(input int k, input logic [7:0] v);
    if (k >= NR) return;
    if (k == 7) return;
    if (k == 8 && v == 8'h00) return;
    mdl[k] = v;
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_en && !fin) begin
      vec++;
      if (cfg !== model_image()) begin
        bad++;
        $display("FAIL R2 register image act=%h exp=%h", cfg, model_image());
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(4); sda_m = 1'b1;
    tick(4); scl_m = 1'b1;
    tick(8); sda_m = 1'b0;
    tick(8); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(4); sda_m = 1'b0;
    tick(4); scl_m = 1'b1;
    tick(8); sda_m = 1'b1;
    tick(8);
  endtask

  // tgt >= 0: byte is expected to land in register tgt (model updated at the ack clock).
  task automatic send_byte(input logic [7:0] b, input int tgt, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(4); sda_m = b[i];
      tick(4); scl_m = 1'b1;
      tick(8);
      if (i == 0) cmp_en = 1'b0;
      scl_m = 1'b0;
    end
    tick(4); sda_m = 1'b1;
    tick(4);
    if (tgt >= 0) model_store(tgt, b);
    cmp_en = 1'b1;
    scl_m = 1'b1;
    tick(4); ack = ~bus;
    tick(4); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(8); scl_m = 1'b1;
      tick(4); b[i] = bus;
      tick(4); scl_m = 1'b0;
    end
    tick(4); sda_m = ~mack;
    tick(4); scl_m = 1'b1;
    tick(8); scl_m = 1'b0;
    tick(4); sda_m = 1'b1;
  endtask

  task automatic wr_txn(input int n);
    logic a;
    bus_start();
    send_byte(8'hD2, -1, a); check(a, "R1 write address ack", a, 1);
    send_byte(8'h5C, -1, a); check(a, "R2 command byte ack", a, 1);
    send_byte(8'h99, -1, a); check(a, "R2 count byte ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], k, a);
      check(a, "R3 data byte ack", a, 1);
    end
    bus_stop();
    check(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
  endtask

  // nack_at < 0: master acks every byte; else master nacks byte index nack_at.
  task automatic rd_txn(input int nack_at);
    logic a;
    logic [7:0] b;
    int last, total, e;
    logic mack;
    bus_start();
    send_byte(8'hD3, -1, a); check(a, "R1 read address ack", a, 1);
    last  = (mdl[8] > NR - 1) ? NR - 1 : mdl[8];
    total = last + 2;
    for (int k = 0; k < total; k++) begin
      e    = (k == 0) ? mdl[8] : mdl[k-1];
      mack = (nack_at < 0) || (k < nack_at);
      recv_byte(mack, b);
      check(b == 8'(e), (k == 0) ? "R6 length byte" : "R6 register byte", b, e);
      if (!mack) break;
    end
    recv_byte(1'b0, b);
    check(b == 8'hFF, (nack_at < 0) ? "R6 released after last" : "R7 released after nack", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < NR; i++) mdl[i] = 0;
    mdl[8] = 8'h08;
    mdl[7] = ID_V;
    tick(5); rst_n = 1'b1; tick(2);
    check(cfg[8*8 +: 8] == 8'h08, "R10 reset length reg", cfg[8*8 +: 8], 8'h08);
    check(cfg[7*8 +: 8] == ID_V, "R10 id reg", cfg[7*8 +: 8], ID_V);
    check(cfg[0 +: 8] == 8'h00, "R10 reg0 reset", cfg[0 +: 8], 0);
    check(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);
    cmp_en = 1'b1;

    // Foreign address: no ack, nothing stored.
    bus_start();
    send_byte(8'hA0, -1, a); check(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h12, -1, a); check(!a, "R1 foreign data nack", a, 0);
    send_byte(8'h34, -1, a);
    bus_stop();
    bus_start();
    send_byte(8'hD4, -1, a); check(!a, "R1 near-miss address nack", a, 0);
    bus_stop();

    // Write regs 0..10, with the id register and a zero length.
    for (int k = 0; k < 11; k++) wbuf[k] = 8'(8'h10 + k * 3);
    wbuf[7] = 8'hEE; wbuf[8] = 8'h00;
    wr_txn(11);
    check(cfg[7*8 +: 8] == ID_V, "R4 id write ignored", cfg[7*8 +: 8], ID_V);
    check(cfg[8*8 +: 8] == 8'h08, "R5 zero length ignored", cfg[8*8 +: 8], 8'h08);
    check(cfg[2*8 +: 8] == 8'h16, "R2 reg2 stored", cfg[2*8 +: 8], 8'h16);
    rd_txn(-1);

    // Over-long write, short length.
    for (int k = 0; k < 24; k++) wbuf[k] = 8'(8'hA0 ^ (k * 7));
    wbuf[8] = 8'h05;
    wr_txn(24);
    check(cfg[20*8 +: 8] == wbuf[20], "R3 last reg stored", cfg[20*8 +: 8], wbuf[20]);
    rd_txn(-1);

    // Length 0x14, full register set.
    for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'h81 + k * 11);
    wbuf[8] = 8'h14;
    wr_txn(9);
    rd_txn(-1);

    // Length past the end is capped at the last register.
    wbuf[8] = 8'h30;
    wr_txn(9);
    rd_txn(-1);

    // Length 7 ends on the id register.
    wbuf[8] = 8'h07;
    wr_txn(9);
    rd_txn(-1);

    // Master nack early.
    rd_txn(3);

    // Repeated start from write into read.
    bus_start();
    send_byte(8'hD2, -1, a); check(a, "R8 write address ack", a, 1);
    send_byte(8'h00, -1, a);
    send_byte(8'h00, -1, a);
    send_byte(8'h5A, 0, a);  check(a, "R8 data before restart", a, 1);
    bus_start();
    send_byte(8'hD3, -1, a); check(a, "R8 read after restart ack", a, 1);
    recv_byte(1'b1, b);      check(b == 8'(mdl[8]), "R8 length after restart", b, mdl[8]);
    recv_byte(1'b0, b);      check(b == 8'h5A, "R8 reg0 after restart", b, 8'h5A);
    bus_stop();
    check(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);

    // Stop in the middle of a write, then a normal write.
    bus_start();
    send_byte(8'hD2, -1, a);
    send_byte(8'h01, -1, a);
    bus_stop();
    check(sda_oe == 1'b0, "R8 stop mid write", sda_oe, 0);
    wbuf[0] = 8'h3C;
    wr_txn(1);
    check(cfg[0 +: 8] == 8'h3C, "R2 write after abort", cfg[0 +: 8], 8'h3C);

    tick(10);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      bad++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule